// File: doc/BRIEF.md
# Wire Turn-On Order Violation Detector

This block watches a bus of N wires, which should be turned on one after another starting at the lowest wire. It takes one sample of the bus per clock cycle and raises an error flag when the stream breaks that order. The order is written as a fixed regular pattern. The pattern has three parts: a low wire 0 in the very first sample; a wire i that is high in one sample while wire i+1 is low in the next sample; or the top wire seen high at any time. The top-wire case latches until reset.

The pattern is not built around a central state machine. It is assembled from small symbol cells, and each cell holds one register. Each cell has an enable input and a recognized output. A cell enabled in a cycle asserts recognized in the next cycle only if its symbol is on the wires in that cycle. Concatenation chains the recognized output of one cell to the enable of the next. Union gives several terms a shared enable and ORs their recognized outputs. A closure feeds a cell's recognized output back into its own enable.

An arming pulse is applied in the first cycle after reset, which anchors the pattern to the start of the stream. An "any" cell that feeds back into itself keeps every later term enabled from then on, so the detector searches the whole stream. The bus is sampled in every cycle and has no handshake. N must be at least 2.

Top module: `seqv_order_detector`

## Requirements
- R1: Symbol encoding: a "high" symbol for wire i matches when `wires_in[i]` is 1, a "low" symbol matches when it is 0, and the "any" symbol matches every sample.
- R2: The first sample after reset is the only one tested for a low wire 0; if `wires_in[0]` is 0 in that sample, `order_err` is 1 in the cycle after it.
- R3: A symbol cell asserts recognized in the cycle after it was enabled and its symbol was present, and asserts nothing otherwise.
- R4: For each i in 0..N-2: if wire i is 1 in sample k and wire i+1 is 0 in sample k+1, `order_err` is 1 in the cycle after sample k+1.
- R5: Every ordered-pair term and the top-wire term stay armed in every sample from the first one on, so matches late in the stream are reported as well as early ones.
- R6: If wire N-1 is 1 in any sample, `order_err` is 1 from the following cycle on, in every cycle until reset.
- R7: While reset is held, and whenever none of the R2, R4 or R6 conditions applies, `order_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the bus is sampled on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wires_in | input | N | Wire levels for the current sample |
| order_err | output | 1 | High when the samples taken so far match the violation pattern |

## Verification
The assertions check these rules in every cycle: each cell reports only after it was enabled; the arming pulse appears once after reset; the "any" loop keeps the terms armed; and a top-wire match holds once it has occurred. Only the bench scenarios can show that the cells form the intended expression. They check the exact cycle in which each pair term fires, that a low wire 0 counts only in the first sample, and that no match is missed late in a long stream. Each output is compared with a reference model built from the sample history.

// File: rtl/seqv_pkg.sv
package seqv_pkg;
  typedef enum logic [1:0] {
    SYM_HIGH = 2'd0,
    SYM_LOW  = 2'd1,
    SYM_ANY  = 2'd2
  } sym_kind_e;
endpackage

// File: rtl/seqv_sym_cell.sv
module seqv_sym_cell
  import seqv_pkg::*;
#(
  parameter sym_kind_e KIND = SYM_HIGH,
  parameter bit        LOOP = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic bit_in,
  output logic rec
);
  logic hit;
  logic en_eff;
  logic rec_q;

  generate
    if (KIND == SYM_HIGH) begin : g_high
      assign hit = bit_in;
    end else if (KIND == SYM_LOW) begin : g_low
      assign hit = ~bit_in;
    end else begin : g_any
      assign hit = 1'b1;
    end
  endgenerate

  assign en_eff = en | (LOOP & rec_q);

  always_ff @(posedge clk) begin
    if (rst) rec_q <= 1'b0;
    else     rec_q <= en_eff & hit;
  end

  assign rec = rec_q;

  AST_REC_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    rec |-> ($past(en) || (LOOP && $past(rec)))); // R3

  generate
    if (KIND == SYM_HIGH && !LOOP) begin : g_chk_high
      AST_HIGH_MISS_SILENT: assert property (@(posedge clk) disable iff (rst)
        (!bit_in) |=> !rec); // R1
    end
    if (KIND == SYM_LOW && !LOOP) begin : g_chk_low
      AST_LOW_MISS_SILENT: assert property (@(posedge clk) disable iff (rst)
        bit_in |=> !rec); // R1
    end
  endgenerate
endmodule

// File: rtl/seqv_pair_term.sv
module seqv_pair_term
  import seqv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic lead,
  input  logic trail,
  output logic hit
);
  logic lead_rec;

  seqv_sym_cell #(.KIND(SYM_HIGH), .LOOP(1'b0)) u_lead (
    .clk(clk), .rst(rst), .en(en), .bit_in(lead), .rec(lead_rec)
  );

  seqv_sym_cell #(.KIND(SYM_LOW), .LOOP(1'b0)) u_trail (
    .clk(clk), .rst(rst), .en(lead_rec), .bit_in(trail), .rec(hit)
  );

  AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(lead_rec)); // R4
endmodule

// File: rtl/seqv_sticky_tail.sv
module seqv_sticky_tail
  import seqv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic top_bit,
  output logic hit
);
  logic top_rec;
  logic hold_rec;

  seqv_sym_cell #(.KIND(SYM_HIGH), .LOOP(1'b0)) u_top (
    .clk(clk), .rst(rst), .en(en), .bit_in(top_bit), .rec(top_rec)
  );

  seqv_sym_cell #(.KIND(SYM_ANY), .LOOP(1'b1)) u_hold (
    .clk(clk), .rst(rst), .en(top_rec), .bit_in(1'b0), .rec(hold_rec)
  );

  assign hit = top_rec | hold_rec;

  AST_TAIL_HOLD: assert property (@(posedge clk) disable iff (rst)
    hit |=> hit); // R6
endmodule

// File: rtl/seqv_order_detector.sv
module seqv_order_detector
  import seqv_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] wires_in,
  output logic         order_err
);
  localparam int NPAIR = N - 1;

  logic             start_q;
  logic             any_rec;
  logic             arm;
  logic             first_low_rec;
  logic [NPAIR-1:0] pair_hit;
  logic             tail_hit;

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b1;
    else     start_q <= 1'b0;
  end

  seqv_sym_cell #(.KIND(SYM_ANY), .LOOP(1'b1)) u_any_loop (
    .clk(clk), .rst(rst), .en(start_q), .bit_in(1'b0), .rec(any_rec)
  );

  assign arm = start_q | any_rec;

  seqv_sym_cell #(.KIND(SYM_LOW), .LOOP(1'b0)) u_first_low (
    .clk(clk), .rst(rst), .en(start_q), .bit_in(wires_in[0]), .rec(first_low_rec)
  );

  generate
    for (genvar gi = 0; gi < NPAIR; gi++) begin : g_pair
      seqv_pair_term u_term (
        .clk(clk), .rst(rst), .en(arm),
        .lead(wires_in[gi]), .trail(wires_in[gi+1]),
        .hit(pair_hit[gi])
      );
    end
  endgenerate

  seqv_sticky_tail u_tail (
    .clk(clk), .rst(rst), .en(arm), .top_bit(wires_in[N-1]), .hit(tail_hit)
  );

  assign order_err = first_low_rec | (|pair_hit) | tail_hit;

  AST_START_ONCE: assert property (@(posedge clk) disable iff (rst)
    !start_q |=> !start_q); // R2
  AST_FIRST_LOW_EARLY: assert property (@(posedge clk) disable iff (rst)
    first_low_rec |-> $past(start_q)); // R2
  AST_ALWAYS_ARMED: assert property (@(posedge clk) disable iff (rst)
    arm); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    tail_hit |=> order_err); // R6
endmodule

// File: tb/seqv_order_detector_bench.sv
module seqv_order_detector_bench;
  localparam int N = 4;
  localparam int MAXL = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] wires_in = '0;
  logic         order_err;

  int errors = 0;
  int checks = 0;
  logic [N-1:0] hist [0:MAXL-1];
  int k = 0;

  always #2.5 clk = ~clk;

  seqv_order_detector #(.N(N)) u_seqv_order_detector (
    .clk(clk), .rst(rst), .wires_in(wires_in), .order_err(order_err)
  );

  function automatic logic ref_err(int cnt);
    logic r = 1'b0;
    if (cnt == 1 && !hist[0][0]) r = 1'b1;
    if (cnt >= 2)
      for (int i = 0; i < N-1; i++)
        if (hist[cnt-2][i] && !hist[cnt-1][i+1]) r = 1'b1;
    for (int s = 0; s < cnt; s++)
      if (hist[s][N-1]) r = 1'b1;
    return r;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s sample %0d: order_err=%b expected %b", req, k, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wires_in = '0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 reset", order_err, 1'b0);
    rst = 1'b0;
    k = 0;
    chk("R7 after reset", order_err, 1'b0);
  endtask

  task automatic step(logic [N-1:0] v, string req);
    wires_in = v;
    hist[k] = v;
    @(posedge clk);
    @(negedge clk);
    k++;
    chk(req, order_err, ref_err(k));
  endtask

  initial begin
    void'($urandom(32'd1981));
    do_reset();
    // R2: low wire 0 only in the first sample, then quiet (R7)
    step(4'b0000, "R2 first low");
    for (int j = 0; j < 4; j++) step(4'b0000, "R7 quiet after first");
    // R1 R4: wire0 high then wire1 low
    do_reset();
    step(4'b0001, "R1 high match");
    step(4'b0001, "R4 pair 0-1");
    step(4'b0011, "R4 no pair");
    step(4'b0111, "R4 ordered");
    step(4'b0111, "R4 pair 2-3");
    // R5: pairs keep firing deep into the stream
    do_reset();
    for (int j = 0; j < 12; j++) step(4'b0001, "R5 armed late");
    // R6: top wire latches
    do_reset();
    step(4'b0001, "R6 pre");
    step(4'b1001, "R6 top seen");
    for (int j = 0; j < 6; j++) step(4'b0000, "R6 sticky");
    // R3 R7: ordered fill with no top wire
    do_reset();
    step(4'b0001, "R3 fill");
    step(4'b0011, "R3 fill");
    step(4'b0111, "R3 fill");
    step(4'b0011, "R3 drop");
    // random runs
    for (int r = 0; r < 30; r++) begin
      do_reset();
      for (int j = 0; j < 20; j++) begin
        logic [N-1:0] v;
        v = N'($urandom);
        if ($urandom % 8 != 0) v[N-1] = 1'b0;
        step(v, "R4 R6 random");
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: timeout actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule